// File: doc/BRIEF.md
# Read-Only Memory Signature Checker

This block walks a region of non-volatile program or constant storage through a plain synchronous read port and reduces its contents to a signature. The result is then judged good or bad. A controller starts a run by giving a base address, a word count, a mode and a reference value. The block then reads the region word by word, from the base address upward, and raises a one-cycle completion pulse. With that pulse it presents a pass flag and the computed signature, and both stay valid until the next run.

Two signature engines can be chosen at run time. The column checksum rotates a 16-bit accumulator left by one place and XORs in each new word. The result is compared with the reference value that was supplied. The CRC engine treats the whole region as one serial bit stream, most significant bit of each word first, and divides it modulo 2 by x^4 + x^3 + 1. The region is expected to end in a word that holds the check remainder, so an intact region leaves a remainder of zero.

Top module: `rom_sig_check`

## Requirements
- R1: After reset, busy, done, pass and mem_rd are 0 and signature is all zeros.
- R2: With mode = 0 (column checksum), the accumulator starts at zero. For each word read, it is rotated left by one bit and then XORed with that word. The signature is the final accumulator, and pass is 1 exactly when it equals the expected input.
- R3: With mode = 1 (CRC), the words are fed as one bit stream, bit 15 of each word first and lowest address first. The stream is divided modulo 2 by 11001b (x^4 + x^3 + 1). The true remainder appears in signature[3:0] with all upper bits 0. Pass is 1 exactly when the remainder is zero, and the expected input is ignored.
- R4: done is high for exactly one cycle at the end of a run, and busy is low from that cycle on. Pass is 0 while busy. Pass and signature hold their values until the next accepted start.
- R5: Counted in rising edges after the edge that accepts start, done becomes visible after 2N+1 edges in checksum mode and after 18N+1 edges in CRC mode, where N is word_count. A run with N = 0 finishes after 1 edge with a signature of 0.
- R6: A start while busy is ignored. The run in progress keeps its base, count, mode and expected value, and its timing does not change.
- R7: For each word, mem_rd is asserted for a single cycle with mem_addr = base + i (modulo the address space). The addresses run i = 0..N-1 in order, and read data is taken on the cycle after mem_rd.
- R8: In checksum mode, flipping an odd number of bits that all lie in the same bit column of different words makes pass 0.
- R9: In CRC mode, flipping any single bit of an intact region makes the remainder nonzero and pass 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (taken only when idle) |
| base_addr | input | ADDR_W | First word address of the region |
| word_count | input | ADDR_W+1 | Number of words in the region |
| mode | input | 1 | 0 = column checksum, 1 = CRC |
| expected | input | DATA_W | Reference for checksum mode |
| mem_rd | output | 1 | Read strobe to the memory |
| mem_addr | output | ADDR_W | Read address |
| mem_rdata | input | DATA_W | Read data, valid the cycle after mem_rd |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Result of the last run |
| signature | output | DATA_W | Signature of the last run |

## Verification
The bench builds the checker with ADDR_W = 6, which gives a 64-word memory model. A region that starts near the top of that space therefore wraps to address zero, so the modulo address sequence can be observed. DATA_W and CRC_W keep their defaults of 16 and 4, so the CRC engine runs a full 16-bit shift per word. This makes the 18-cycle-per-word timing and the appended-remainder construction checkable with short regions.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_LOAD,
        ST_SHIFT,
        ST_FINISH
    } seq_state_e;

    typedef enum logic {
        MODE_COLSUM = 1'b0,
        MODE_CRC    = 1'b1
    } sig_mode_e;

endpackage

// File: rtl/rsc_addr_seq.sv
module rsc_addr_seq #(
    parameter int ADDR_W = 8,
    parameter int LEN_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic [LEN_W-1:0]  len,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              exhausted
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  remain;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d = q;
        if (load) begin
            d.addr   = base;
            d.remain = len;
        end else if (step) begin
            d.addr   = q.addr + 1'b1;
            d.remain = q.remain - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign addr      = q.addr;
    assign exhausted = (q.remain == '0);

endmodule

// File: rtl/rsc_colsum.sv
module rsc_colsum #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              fold,
    input  logic [DATA_W-1:0] word,
    output logic [DATA_W-1:0] acc
);

    typedef struct packed {
        logic [DATA_W-1:0] acc;
    } cs_t;

    cs_t q, d;

    always_comb begin
        d = q;
        if (clear)
            d.acc = '0;
        else if (fold)
            d.acc = {q.acc[DATA_W-2:0], q.acc[DATA_W-1]} ^ word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign acc = q.acc;

endmodule

// File: rtl/rsc_crc_serial.sv
module rsc_crc_serial #(
    parameter int                DATA_W   = 16,
    parameter int                CRC_W    = 4,
    parameter logic [CRC_W-1:0]  CRC_POLY = 4'b1001,
    localparam int               CNT_W    = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load,
    input  logic              shift,
    input  logic [DATA_W-1:0] word,
    output logic [CRC_W-1:0]  rem,
    output logic              last_bit
);

    typedef struct packed {
        logic [DATA_W-1:0] sreg;
        logic [CRC_W-1:0]  rem;
        logic [CNT_W-1:0]  cnt;
    } crc_t;

    crc_t q, d;
    logic [CRC_W-1:0] stepped;

    always_comb begin
        stepped = {q.rem[CRC_W-2:0], q.sreg[DATA_W-1]};
        if (q.rem[CRC_W-1])
            stepped = stepped ^ CRC_POLY;
        d = q;
        if (clear) begin
            d = '0;
        end else if (load) begin
            d.sreg = word;
            d.cnt  = '0;
        end else if (shift) begin
            d.sreg = {q.sreg[DATA_W-2:0], 1'b0};
            d.rem  = stepped;
            d.cnt  = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rem      = q.rem;
    assign last_bit = (q.cnt == CNT_W'(DATA_W - 1));

endmodule

// File: rtl/rom_sig_check.sv
module rom_sig_check
    import rsc_pkg::*;
#(
    parameter int               ADDR_W   = 8,
    parameter int               DATA_W   = 16,
    parameter int               CRC_W    = 4,
    parameter logic [CRC_W-1:0] CRC_POLY = 4'b1001,
    localparam int              LEN_W    = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [LEN_W-1:0]  word_count,
    input  logic              mode,
    input  logic [DATA_W-1:0] expected,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic [DATA_W-1:0] signature
);

    typedef struct packed {
        seq_state_e        state;
        sig_mode_e         mode;
        logic [DATA_W-1:0] expect_val;
        logic              done;
        logic              pass;
        logic [DATA_W-1:0] sig;
    } ctl_t;

    ctl_t q, d;

    logic              seq_load, seq_step, seq_exhausted;
    logic              cs_clear, cs_fold;
    logic              crc_clear, crc_load, crc_shift, crc_last;
    logic [DATA_W-1:0] cs_acc;
    logic [CRC_W-1:0]  crc_rem;
    logic [DATA_W-1:0] crc_sig;
    logic              crc_active;

    always_comb begin
        crc_sig = '0;
        crc_sig[CRC_W-1:0] = crc_rem;
    end

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        seq_load  = 1'b0;
        seq_step  = 1'b0;
        cs_clear  = 1'b0;
        cs_fold   = 1'b0;
        crc_clear = 1'b0;
        crc_load  = 1'b0;
        crc_shift = 1'b0;
        mem_rd    = 1'b0;
        unique case (q.state)
            ST_IDLE: begin
                if (start) begin
                    d.mode       = sig_mode_e'(mode);
                    d.expect_val = expected;
                    d.pass       = 1'b0;
                    seq_load     = 1'b1;
                    cs_clear     = 1'b1;
                    crc_clear    = 1'b1;
                    d.state      = (word_count == '0) ? ST_FINISH : ST_FETCH;
                end
            end
            ST_FETCH: begin
                mem_rd   = 1'b1;
                seq_step = 1'b1;
                d.state  = ST_LOAD;
            end
            ST_LOAD: begin
                if (q.mode == MODE_CRC) begin
                    crc_load = 1'b1;
                    d.state  = ST_SHIFT;
                end else begin
                    cs_fold  = 1'b1;
                    d.state  = seq_exhausted ? ST_FINISH : ST_FETCH;
                end
            end
            ST_SHIFT: begin
                crc_shift = 1'b1;
                if (crc_last)
                    d.state = seq_exhausted ? ST_FINISH : ST_FETCH;
            end
            ST_FINISH: begin
                d.done  = 1'b1;
                d.state = ST_IDLE;
                if (q.mode == MODE_CRC) begin
                    d.sig  = crc_sig;
                    d.pass = (crc_rem == '0);
                end else begin
                    d.sig  = cs_acc;
                    d.pass = (cs_acc == q.expect_val);
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
            q.mode  <= MODE_COLSUM;
        end else begin
            q <= d;
        end
    end

    rsc_addr_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (seq_load),
        .base      (base_addr),
        .len       (word_count),
        .step      (seq_step),
        .addr      (mem_addr),
        .exhausted (seq_exhausted)
    );

    rsc_colsum #(.DATA_W(DATA_W)) u_colsum (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cs_clear),
        .fold  (cs_fold),
        .word  (mem_rdata),
        .acc   (cs_acc)
    );

    rsc_crc_serial #(.DATA_W(DATA_W), .CRC_W(CRC_W), .CRC_POLY(CRC_POLY)) u_crc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (crc_clear),
        .load     (crc_load),
        .shift    (crc_shift),
        .word     (mem_rdata),
        .rem      (crc_rem),
        .last_bit (crc_last)
    );

    assign crc_active = (q.mode == MODE_CRC);
    assign busy       = (q.state != ST_IDLE);
    assign done       = q.done;
    assign pass       = q.pass;
    assign signature  = q.sig;

endmodule

// File: rtl/rsc_checker.sv
module rsc_checker #(
    parameter int DATA_W = 16,
    parameter int CRC_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              pass,
    input logic              mem_rd,
    input logic              crc_active,
    input logic [DATA_W-1:0] signature
);

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R4
    pass_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !pass);

    // R7
    rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    // R7
    rd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> busy);

    // R3
    crc_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && crc_active) |-> ((signature >> CRC_W) == '0));

    // R6
    start_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

endmodule

bind rom_sig_check rsc_checker #(.DATA_W(DATA_W), .CRC_W(CRC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .pass       (pass),
    .mem_rd     (mem_rd),
    .crc_active (crc_active),
    .signature  (signature)
);

// File: tb/rom_sig_check_bench.sv
module rom_sig_check_bench;

    localparam int AW = 6;
    localparam int DW = 16;
    localparam int CW = 4;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic [AW:0]   word_count = '0;
    logic          mode = 1'b0;
    logic [DW-1:0] expected = '0;
    logic          mem_rd;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_rdata;
    logic          busy, done, pass;
    logic [DW-1:0] signature;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] trace [1024];
    int            tr_n = 0;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    rom_sig_check #(.ADDR_W(AW), .DATA_W(DW), .CRC_W(CW)) u_rom_sig_check (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .base_addr  (base_addr),
        .word_count (word_count),
        .mode       (mode),
        .expected   (expected),
        .mem_rd     (mem_rd),
        .mem_addr   (mem_addr),
        .mem_rdata  (mem_rdata),
        .busy       (busy),
        .done       (done),
        .pass       (pass),
        .signature  (signature)
    );

    always_ff @(posedge clk) begin
        if (mem_rd) begin
            mem_rdata       <= mem[mem_addr];
            trace[tr_n % 1024] <= mem_addr;
            tr_n            <= tr_n + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] colsum_model(input int b, input int n);
        logic [DW-1:0] a = '0;
        for (int i = 0; i < n; i++)
            a = {a[DW-2:0], a[DW-1]} ^ mem[(b + i) % DEPTH];
        return a;
    endfunction

    function automatic logic [CW-1:0] crc_model(input int b, input int n);
        logic [CW:0] r = '0;
        for (int i = 0; i < n; i++)
            for (int k = DW - 1; k >= 0; k--) begin
                r = {r[CW-1:0], mem[(b + i) % DEPTH][k]};
                if (r[CW]) r = r ^ 5'b11001;
            end
        return r[CW-1:0];
    endfunction

    // Runs one job; returns edges from accept to visible done. inj=1 pulses a
    // competing start three cycles into the run.
    task automatic run(input int b, input int n, input logic m, input logic [DW-1:0] e,
                       input bit inj, output int cyc);
        @(negedge clk);
        base_addr = AW'(b); word_count = (AW+1)'(n); mode = m; expected = e; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        do begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (inj && cyc == 3) begin
                base_addr = AW'(40); word_count = 7'd2; mode = ~m; expected = ~e; start = 1'b1;
            end else begin
                start = 1'b0;
            end
        end while (!done && cyc < 20000);
    endtask

    task automatic t_reset();
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 pass", pass, 0);
        check("R1 mem_rd", mem_rd, 0);
        check("R1 signature", signature, 0);
    endtask

    task automatic t_checksum_basic();
        int cyc; int t0; logic [DW-1:0] m;
        m = colsum_model(3, 5);
        t0 = tr_n;
        run(3, 5, 1'b0, m, 0, cyc);
        check("R2 signature", signature, m);
        check("R2 pass", pass, 1);
        check("R5 checksum latency", cyc, 2 * 5 + 1);
        check("R4 busy low at done", busy, 0);
        for (int i = 0; i < 5; i++) check("R7 address order", trace[(t0 + i) % 1024], 32'(3 + i));
        check("R7 read count", tr_n - t0, 5);
        @(negedge clk);
        check("R4 done one cycle", done, 0);
        check("R4 pass held", pass, 1);
        check("R4 signature held", signature, m);
    endtask

    task automatic t_checksum_mismatch();
        int cyc; logic [DW-1:0] m;
        m = colsum_model(7, 9);
        run(7, 9, 1'b0, m ^ 16'h0100, 0, cyc);
        check("R2 mismatch pass", pass, 0);
        check("R2 mismatch signature", signature, m);
    endtask

    task automatic t_wrap();
        int cyc; int t0; logic [DW-1:0] m;
        m = colsum_model(60, 8);
        t0 = tr_n;
        run(60, 8, 1'b0, m, 0, cyc);
        check("R7 wrap signature", signature, m);
        check("R7 wrap pass", pass, 1);
        check("R7 wrap address", trace[(t0 + 4) % 1024], 0);
    endtask

    task automatic t_crc();
        int cyc; logic [CW-1:0] r; logic [DW-1:0] saved;
        mem[14] = '0;
        r = crc_model(10, 5);
        mem[14] = {12'h000, r};
        check("R3 model residue zero", crc_model(10, 5), 0);
        run(10, 5, 1'b1, 16'hBEEF, 0, cyc);
        check("R3 intact signature", signature, 0);
        check("R3 intact pass", pass, 1);
        check("R5 crc latency", cyc, 18 * 5 + 1);
        saved = mem[11];
        mem[11] = mem[11] ^ 16'h0080;
        r = crc_model(10, 5);
        run(10, 5, 1'b1, 16'h0000, 0, cyc);
        check("R9 single flip signature", signature, r);
        check("R9 single flip nonzero", (r != 0), 1);
        check("R9 single flip pass", pass, 0);
        mem[11] = saved;
        run(12, 3, 1'b1, 16'h0, 0, cyc);
        check("R3 plain remainder", signature, crc_model(12, 3));
    endtask

    task automatic t_zero_len();
        int cyc;
        run(5, 0, 1'b0, 16'h0000, 0, cyc);
        check("R5 zero length latency", cyc, 1);
        check("R5 zero length signature", signature, 0);
        check("R5 zero length pass", pass, 1);
        run(5, 0, 1'b1, 16'hFFFF, 0, cyc);
        check("R3 expected ignored", pass, 1);
    endtask

    task automatic t_busy_start();
        int cyc; logic [DW-1:0] m;
        m = colsum_model(3, 5);
        run(3, 5, 1'b0, m, 1, cyc);
        check("R6 result kept", signature, m);
        check("R6 pass kept", pass, 1);
        check("R6 timing kept", cyc, 11);
    endtask

    task automatic t_odd_column();
        int cyc; logic [DW-1:0] m; logic [DW-1:0] s0, s1, s2;
        m = colsum_model(20, 8);
        s0 = mem[20]; s1 = mem[22]; s2 = mem[25];
        mem[20] = s0 ^ 16'h0020; mem[22] = s1 ^ 16'h0020; mem[25] = s2 ^ 16'h0020;
        run(20, 8, 1'b0, m, 0, cyc);
        check("R8 odd column fail", pass, 0);
        mem[20] = s0; mem[22] = s1; mem[25] = s2;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++)
            mem[i] = DW'((i * 16'h1357) ^ 16'hA5C3) + DW'(i);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_checksum_basic();
        t_checksum_mismatch();
        t_wrap();
        t_crc();
        t_zero_len();
        t_busy_start();
        t_odd_column();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule